// File: doc/BRIEF.md
# LIN Header Break and Sync Receiver

This block is the front end of a LIN slave receiver. It runs before ordinary UART byte reception and handles the two fields that start every frame header. While enabled and idle, it waits for any edge on the receive line; that edge is the wakeup event and arms a break-reception mode. In that mode the block measures how long the line stays low, in units of a programmed nominal bit period. When the line returns high it decides whether the low time was a valid break.

A valid break is at least 11 nominal bit times long. The master sends 13 bit times, so the margin absorbs a baud mismatch. A valid break raises a one-cycle completion pulse, and the block then times the 0x55 sync field that follows. A shorter low time is dropped silently: no pulse is raised and the block re-arms for the next break. While break and sync reception are in progress, an inhibit output tells the downstream byte receiver to do three things: suppress its overrun, parity and framing flags, move no data into its receive buffer, and keep its shift register at all ones.

The measured bit period leaves on a valid/ready output. After it has been accepted, the block stays halted, so the baud generator can be reprogrammed, until the enable input is dropped. If the sync edges do not arrive in time, a timeout status is raised and the block goes back to waiting for a wakeup edge.

Top module: `lin_hdr_rx`

## Requirements
- R1: After reset, with `enable` low, `brk_done`, `byte_rx_inhibit`, `sync_valid` and `sync_timeout` are all 0.
- R2: When enabled and idle, any edge on `rxd` is a wakeup. `byte_rx_inhibit` rises on the third clock edge after the change on `rxd`, and stays 0 while the line holds steady.
- R3: In break mode, the low time L (in clocks) counts as floor(L / `nom_period`) bits, with a saturating 16-bit counter. If that count is 11 or more when the line goes high, `brk_done` is high for exactly one cycle, starting on the third clock edge after the rise. `nom_period` must be 2 or more.
- R4: A low time of fewer than 11 bits gives no `brk_done` pulse. The block stays in break mode and accepts the next valid break without a new wakeup edge.
- R5: `byte_rx_inhibit` is high from the wakeup through break reception, sync measurement and the pending report.
- R6: `sync_period` is floor((T5 - T1) / 8), where T1 and T5 are the clock times of the first and fifth falling edges on `rxd` after a valid break. Those edges span the 8 bit times of the 0x55 sync field.
- R7: `sync_valid` rises on the third clock edge after the fifth falling edge of the sync field.
- R8: While `sync_valid` is high and `sync_ready` is low, `sync_valid` and `sync_period` hold. The cycle after a transfer (`sync_valid` and `sync_ready` both high), `sync_valid` and `byte_rx_inhibit` are 0. The block then ignores `rxd` until `enable` goes low.
- R9: If 32 nominal bit times pass in sync measurement without the fifth falling edge, `sync_timeout` rises on edge 32*`nom_period`+1 after the `brk_done` edge. At the same time `byte_rx_inhibit` drops and the block waits for a wakeup. The next valid break clears `sync_timeout`.
- R10: `enable` low forces the idle state on the next clock edge: `byte_rx_inhibit`, `sync_valid` and `brk_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the receiver when high; low returns it to idle |
| rxd | input | 1 | Serial receive line, asynchronous, idle high |
| nom_period | input | 16 | Nominal bit period in clocks (2 or more) |
| brk_done | output | 1 | One-cycle pulse on a valid break |
| byte_rx_inhibit | output | 1 | Byte receiver must suppress error flags and buffer transfers |
| sync_valid | output | 1 | Measured bit period available |
| sync_ready | input | 1 | Consumer accepts the measured period |
| sync_period | output | 16 | Measured bit period in clocks |
| sync_timeout | output | 1 | Sync field did not complete in time |

## Verification
Every result that follows a change on `rxd` passes two synchronizer flops and one state register. The wakeup inhibit, the break pulse and the sync valid are therefore each due on the third clock edge after the line changes. The bench drives `rxd` and samples outputs on falling clock edges, and checks each of these results on the second edge, where it must still be 0, and again on the third. The timeout is due 32*`nom_period`+1 edges after the break pulse, so it is sampled one edge before and on that edge. Back-pressure is checked by holding `sync_ready` low for several cycles and comparing the held value.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_WAKE   = 3'd1,
    ST_ARM    = 3'd2,
    ST_LOW    = 3'd3,
    ST_SYNC   = 3'd4,
    ST_REPORT = 3'd5,
    ST_HALT   = 3'd6
  } hdr_state_t;

  function automatic logic in_header(input hdr_state_t s);
    return (s == ST_ARM) || (s == ST_LOW) || (s == ST_SYNC) || (s == ST_REPORT);
  endfunction

endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic rx_s,
  output logic rx_fall,
  output logic rx_edge
);

  logic [STAGES-1:0] chain;
  logic              rx_prev;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= rx_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rx_s = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_s;
  end

  assign rx_fall = rx_prev & ~rx_s;
  assign rx_edge = rx_prev ^ rx_s;

  // R6: a falling edge is never reported on two cycles in a row
  a_r6_fall_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall |=> !rx_fall);

endmodule

// File: rtl/lin_bit_meter.sv
module lin_bit_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             seed,
  input  logic             run,
  input  logic [CNT_W-1:0] nom_period,
  output logic [CNT_W-1:0] bits
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ccnt;
  logic             wrap;

  assign wrap = (ccnt >= nom_period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt <= '0;
      bits <= '0;
    end else if (clr) begin
      ccnt <= {{(CNT_W-1){1'b0}}, seed};
      bits <= '0;
    end else if (run) begin
      if (wrap) begin
        ccnt <= '0;
        if (bits != MAXV) bits <= bits + 1'b1;
      end else begin
        ccnt <= ccnt + 1'b1;
      end
    end
  end

  // R3: the bit count never decreases without a clear and saturates at its top
  a_r3_bits_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> bits >= $past(bits));

endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
  parameter int CNT_W     = 16,
  parameter int SPAN_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             fall,
  output logic             done,
  output logic [CNT_W-1:0] period
);

  localparam int EDGES = SPAN_BITS / 2 + 1;
  localparam int SHIFT = $clog2(SPAN_BITS);
  localparam int FC_W  = $clog2(EDGES + 1);
  localparam logic [FC_W-1:0] LAST = FC_W'(EDGES - 1);

  logic [CNT_W-1:0] ts;
  logic [CNT_W-1:0] t_first;
  logic [CNT_W-1:0] span;
  logic [FC_W-1:0]  fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts      <= '0;
      t_first <= '0;
      fcnt    <= '0;
    end else if (clr) begin
      ts      <= '0;
      t_first <= '0;
      fcnt    <= '0;
    end else if (run) begin
      ts <= ts + 1'b1;
      if (fall && fcnt != LAST) begin
        fcnt <= fcnt + 1'b1;
        if (fcnt == '0) t_first <= ts;
      end
    end
  end

  assign span   = ts - t_first;
  assign done   = run && fall && (fcnt == LAST);
  assign period = span >> SHIFT;

  // R6: the edge count never runs past the edge that closes the span
  a_r6_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= LAST);

  // R6: each counted falling edge advances the edge count by one
  a_r6_edge_step: assert property (@(posedge clk) disable iff (!rst_n)
    run && fall && !clr && fcnt != LAST |=> fcnt == $past(fcnt) + 1'b1);

endmodule

// File: rtl/lin_hdr_rx.sv
module lin_hdr_rx
  import lin_hdr_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int BRK_BITS     = 11,
  parameter int TIMEOUT_BITS = 32,
  parameter int SPAN_BITS    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rxd,
  input  logic [CNT_W-1:0] nom_period,
  output logic             brk_done,
  output logic             byte_rx_inhibit,
  output logic             sync_valid,
  input  logic             sync_ready,
  output logic [CNT_W-1:0] sync_period,
  output logic             sync_timeout
);

  localparam logic [CNT_W-1:0] BRK_MIN = CNT_W'(BRK_BITS);
  localparam logic [CNT_W-1:0] TO_MAX  = CNT_W'(TIMEOUT_BITS);

  hdr_state_t       state, state_n;
  logic             rx_s, rx_fall, rx_edge;
  logic [CNT_W-1:0] bits;
  logic             meter_clr, meter_seed, meter_run;
  logic             sync_done;
  logic [CNT_W-1:0] meas;
  logic             brk_ok, to_hit;
  logic             brk_q, to_q;
  logic [CNT_W-1:0] period_q;

  lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_async (rxd),
    .rx_s     (rx_s),
    .rx_fall  (rx_fall),
    .rx_edge  (rx_edge)
  );

  lin_bit_meter #(.CNT_W(CNT_W)) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (meter_clr),
    .seed       (meter_seed),
    .run        (meter_run),
    .nom_period (nom_period),
    .bits       (bits)
  );

  lin_sync_meter #(.CNT_W(CNT_W), .SPAN_BITS(SPAN_BITS)) u_meas (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (meter_clr),
    .run    (state == ST_SYNC),
    .fall   (rx_fall),
    .done   (sync_done),
    .period (meas)
  );

  assign brk_ok = (bits >= BRK_MIN);
  assign to_hit = (bits >= TO_MAX);

  always_comb begin
    state_n = state;
    if (!enable) begin
      state_n = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:    state_n = ST_WAKE;
        ST_WAKE:   if (rx_edge) state_n = ST_ARM;
        ST_ARM:    if (!rx_s) state_n = ST_LOW;
        ST_LOW:    if (rx_s) state_n = brk_ok ? ST_SYNC : ST_ARM;
        ST_SYNC: begin
          if (sync_done)   state_n = ST_REPORT;
          else if (to_hit) state_n = ST_WAKE;
        end
        ST_REPORT: if (sync_ready) state_n = ST_HALT;
        ST_HALT:   state_n = ST_HALT;
        default:   state_n = ST_OFF;
      endcase
    end
  end

  // Counters restart on every state change; the break count is seeded with
  // the low cycle that caused the entry into the low-counting state.
  assign meter_clr  = (state_n != state);
  assign meter_seed = (state_n == ST_LOW);
  assign meter_run  = (state == ST_SYNC) || ((state == ST_LOW) && !rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      brk_q    <= 1'b0;
      to_q     <= 1'b0;
      period_q <= '0;
    end else begin
      state <= state_n;
      brk_q <= (state == ST_LOW) && (state_n == ST_SYNC);
      if ((state == ST_SYNC) && (state_n == ST_WAKE))
        to_q <= 1'b1;
      else if ((state == ST_LOW) && (state_n == ST_SYNC))
        to_q <= 1'b0;
      if ((state == ST_SYNC) && (state_n == ST_REPORT))
        period_q <= meas;
    end
  end

  assign brk_done        = brk_q;
  assign sync_timeout    = to_q;
  assign sync_valid      = (state == ST_REPORT);
  assign sync_period     = period_q;
  assign byte_rx_inhibit = in_header(state);

  // R3: the break completion pulse lasts one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);

  // R3: the bit period setting is legal while running
  a_r3_nom_legal: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> nom_period >= 2);

  // R2: header mode is entered only from the wakeup wait
  a_r2_wake_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_rx_inhibit) |-> $past(state) == ST_WAKE);

  // R8: a pending measurement holds under back-pressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid && !sync_ready && enable |=> sync_valid && $stable(sync_period));

  // R8: a transfer ends the report and releases the byte receiver
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid && sync_ready && enable |=> !sync_valid && !byte_rx_inhibit);

  // R9: a timeout leaves header mode
  a_r9_timeout_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_timeout) |-> !byte_rx_inhibit);

  // R10: disabling returns to idle on the next edge
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !byte_rx_inhibit && !sync_valid && !brk_done);

endmodule

// File: tb/lin_hdr_rx_bench.sv
module lin_hdr_rx_bench;

  localparam int CLK_NS = 10;
  localparam int NOM    = 8;
  localparam int WD_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] nom_period = 16'(NOM);
  logic        sync_ready = 1'b0;
  logic        brk_done, byte_rx_inhibit, sync_valid, sync_timeout;
  logic [15:0] sync_period;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS / 2) clk = ~clk;

  lin_hdr_rx u_lin_hdr_rx (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .rxd             (rxd),
    .nom_period      (nom_period),
    .brk_done        (brk_done),
    .byte_rx_inhibit (byte_rx_inhibit),
    .sync_valid      (sync_valid),
    .sync_ready      (sync_ready),
    .sync_period     (sync_period),
    .sync_timeout    (sync_timeout)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic watch(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      pulses += int'(brk_done);
    end
  endtask

  task automatic restart();
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(2);
  endtask

  task automatic wakeup();
    rxd = 1'b0;
    step(2 * NOM);
    rxd = 1'b1;
    step(6);
  endtask

  // Ends on the sample right after the brk_done edge.
  task automatic break_ok(input int len);
    rxd = 1'b0;
    step(len);
    rxd = 1'b1;
    step(2);
    chk("R3 pulse early", int'(brk_done), 0);
    step(1);
    chk("R3 pulse due", int'(brk_done), 1);
  endtask

  // Drives the 0x55 frame up to its fifth falling edge and checks the report.
  task automatic send_sync(input int b, input int extra, input int exp);
    step(NOM);
    for (int i = 0; i < 9; i++) begin
      rxd = (i == 0) ? 1'b0 : ((8'h55 >> (i - 1)) & 1) != 0;
      if (i == 8) break;
      chk("R5 inhibit in sync", int'(byte_rx_inhibit), 1);
      step(b + ((i == 7) ? extra : 0));
    end
    step(2);
    chk("R7 valid early", int'(sync_valid), 0);
    step(1);
    chk("R7 valid due", int'(sync_valid), 1);
    chk("R6 period", int'(sync_period), exp);
    rxd = 1'b1;
  endtask

  task automatic t_reset();
    step(3);
    rst_n = 1'b1;
    step(2);
    chk("R1 brk_done", int'(brk_done), 0);
    chk("R1 inhibit", int'(byte_rx_inhibit), 0);
    chk("R1 valid", int'(sync_valid), 0);
    chk("R1 timeout", int'(sync_timeout), 0);
  endtask

  task automatic t_wakeup();
    int p;
    enable = 1'b1;
    step(8);
    chk("R2 idle line", int'(byte_rx_inhibit), 0);
    rxd = 1'b0;
    step(2);
    chk("R2 inhibit early", int'(byte_rx_inhibit), 0);
    step(1);
    chk("R2 inhibit due", int'(byte_rx_inhibit), 1);
    step(2 * NOM - 3);
    rxd = 1'b1;
    watch(8, p);
    chk("R4 wake pulse no break", p, 0);
    chk("R5 inhibit kept", int'(byte_rx_inhibit), 1);
  endtask

  task automatic t_short_break();
    int p;
    rxd = 1'b0;
    step(11 * NOM - 1);
    rxd = 1'b1;
    watch(8, p);
    chk("R4 short break", p, 0);
    chk("R4 re-armed", int'(byte_rx_inhibit), 1);
  endtask

  task automatic t_exact_break();
    break_ok(11 * NOM);
    step(1);
    chk("R3 single cycle", int'(brk_done), 0);
    send_sync(NOM, 0, NOM);
  endtask

  task automatic t_handshake();
    int p;
    logic [15:0] held;
    held = sync_period;
    step(5);
    chk("R8 valid held", int'(sync_valid), 1);
    chk("R8 period held", int'(sync_period), int'(held));
    sync_ready = 1'b1;
    step(1);
    sync_ready = 1'b0;
    chk("R8 valid drop", int'(sync_valid), 0);
    chk("R8 inhibit drop", int'(byte_rx_inhibit), 0);
    rxd = 1'b0;
    step(13 * NOM);
    rxd = 1'b1;
    watch(8, p);
    chk("R8 halted pulses", p, 0);
    chk("R8 halted inhibit", int'(byte_rx_inhibit), 0);
    chk("R8 halted valid", int'(sync_valid), 0);
  endtask

  task automatic t_baud();
    restart();
    wakeup();
    break_ok(13 * NOM);
    send_sync(10, 7, 10);
    sync_ready = 1'b1;
    step(1);
    sync_ready = 1'b0;
    restart();
    wakeup();
    break_ok(13 * NOM);
    send_sync(6, 9, 7);
    sync_ready = 1'b1;
    step(1);
    sync_ready = 1'b0;
  endtask

  task automatic t_timeout();
    restart();
    wakeup();
    break_ok(13 * NOM);
    step(32 * NOM);
    chk("R9 timeout early", int'(sync_timeout), 0);
    chk("R5 inhibit before timeout", int'(byte_rx_inhibit), 1);
    step(1);
    chk("R9 timeout due", int'(sync_timeout), 1);
    chk("R9 inhibit off", int'(byte_rx_inhibit), 0);
    wakeup();
    chk("R9 wake again", int'(byte_rx_inhibit), 1);
    break_ok(12 * NOM);
    chk("R9 timeout cleared", int'(sync_timeout), 0);
  endtask

  task automatic t_abort();
    step(NOM);
    rxd = 1'b0;
    step(NOM);
    enable = 1'b0;
    step(1);
    chk("R10 inhibit off", int'(byte_rx_inhibit), 0);
    chk("R10 valid off", int'(sync_valid), 0);
    rxd = 1'b1;
    enable = 1'b1;
    step(2);
    wakeup();
    break_ok(13 * NOM);
    send_sync(9, 0, 9);
    enable = 1'b0;
    step(1);
    chk("R10 report aborted", int'(sync_valid), 0);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", WD_CYC);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wakeup();
    t_short_break();
    t_exact_break();
    t_handshake();
    t_baud();
    t_timeout();
    t_abort();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule